// File: doc/BRIEF.md
# PLL Configuration Register Bank with Status Interlocks

This block holds the configuration of one clock-synthesis PLL behind a small word-wide register bus. Software picks the reference source, the reference prescaler, the input frequency band, the VCO band, three divided-output enables and a fractional multiplier value. Live status from the PLLs (one on bit and one ready bit per PLL) decides which fields a write may change. Fields that are write-protected at that moment keep their old value, while the unprotected fields of the same word still take the new data.

The fractional value is held in two places. The first is a bus-visible register. The second is a modulator-side copy, which is loaded only when the latch-enable bit goes from 0 to 1. A sticky error bit records every write whose protected data was dropped. Software clears it by writing 1 to it.

Top module: `pll_cfg_regs`

## Requirements
- R1: While rst_ni is low, every configuration output, the fractional value, the modulator copy and the error flag read 0.
- R2: The reference source select (word 0, bits [1:0]; 0 = off, 1 = internal fast oscillator, 2 = internal low-power oscillator, 3 = external crystal) changes on a write only when every bit of pll_on_i and of pll_rdy_i is 0. Otherwise it keeps its value.
- R3: The reference prescaler (word 0, bits [7:2]; 0 = off, 1 = bypass, N = divide by N) keeps its value on a write while pll_on_i[0] or pll_rdy_i[0] is 1.
- R4: The P, Q and R output enables (word 0, bits 11, 12 and 13) change on a write only when pll_on_i[0] and pll_rdy_i[0] are both 0.
- R5: The input band (word 0, bits [9:8]) and the VCO band select (word 0, bit 10; 0 = wide, 1 = medium) take every write to word 0, including writes whose protected fields are blocked.
- R6: The modulator copy loads the fractional value only on a word-0 write that sets the latch bit (bit 14) while the stored latch bit is 0. A write of 1 while the bit is already 1 leaves the copy unchanged.
- R7: The error flag (word 2, bit 0) is set by a word-0 write in which a blocked field's write data differs from its stored value. It stays set until a write to word 2 with bit 0 set.
- R8: Reads return the stored values: word 0 as laid out above, word 1 as the fractional value zero-extended, word 2 as the error flag. Word 3 reads 0.
- R9: The fractional value (word 1, bits [12:0]) takes every write to word 1, whatever the status inputs are, and appears on frac_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 2 | Word address |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for addr_i |
| pll_on_i | input | 3 | Per-PLL on status; bit 0 is the PLL configured here |
| pll_rdy_i | input | 3 | Per-PLL ready status; bit 0 is the PLL configured here |
| src_sel_o | output | 2 | Reference source select |
| ref_div_o | output | 6 | Reference prescaler value |
| in_range_o | output | 2 | Input frequency band |
| vco_med_o | output | 1 | VCO band select, 1 = medium |
| p_en_o | output | 1 | P output enable |
| q_en_o | output | 1 | Q output enable |
| r_en_o | output | 1 | R output enable |
| frac_o | output | 13 | Bus-side fractional value |
| frac_mod_o | output | 13 | Modulator-side fractional copy |
| err_o | output | 1 | Sticky blocked-write flag |

## Verification
A wrong interlock decode shows up on the cycle right after a write, either as a protected output that moved or as an unprotected output that failed to move. The error flag confirms the same decision. A latch bit stored in the wrong state shows up as frac_mod_o reloading on a repeated 1, or missing the next true rising write, so the modulator copy diverges from a frac_o value written earlier. The bench sweeps all 64 status combinations with varied data, so every one of these shows up within one write.

// File: rtl/pll_cfg_pkg.sv
package pll_cfg_pkg;
  localparam int unsigned DATA_W = 16;
  localparam int unsigned ADDR_W = 2;
  localparam int unsigned FRAC_W = 13;
  localparam int unsigned DIV_W  = 6;
  localparam int unsigned N_EN   = 3;

  localparam logic [ADDR_W-1:0] A_CFG  = 2'd0;
  localparam logic [ADDR_W-1:0] A_FRAC = 2'd1;
  localparam logic [ADDR_W-1:0] A_ERR  = 2'd2;

  // word 0 field positions
  localparam int unsigned B_SRC   = 0;
  localparam int unsigned B_DIV   = 2;
  localparam int unsigned B_RNG   = 8;
  localparam int unsigned B_VCO   = 10;
  localparam int unsigned B_EN    = 11;
  localparam int unsigned B_LATCH = 14;

  typedef enum logic [1:0] {
    SRC_OFF  = 2'd0,
    SRC_FAST = 2'd1,
    SRC_LP   = 2'd2,
    SRC_XTAL = 2'd3
  } src_e;

  typedef struct packed {
    logic             latch;
    logic [N_EN-1:0]  en;
    logic             vco_med;
    logic [1:0]       rng;
    logic [DIV_W-1:0] div;
    src_e             src;
  } cfg_t;
endpackage

// File: rtl/pll_cfg_lock.sv
module pll_cfg_lock #(
  parameter int unsigned NUM_PLL = 3
) (
  input  logic [NUM_PLL-1:0] pll_on_i,
  input  logic [NUM_PLL-1:0] pll_rdy_i,
  output logic               all_off_o,
  output logic               own_off_o
);
  assign all_off_o = ~|(pll_on_i | pll_rdy_i);
  assign own_off_o = ~(pll_on_i[0] | pll_rdy_i[0]);
endmodule

// File: rtl/pll_cfg_frac.sv
module pll_cfg_frac #(
  parameter int unsigned FRAC_W = 13
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [FRAC_W-1:0] wdata_i,
  input  logic              load_i,
  output logic [FRAC_W-1:0] frac_o,
  output logic [FRAC_W-1:0] mod_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frac_o <= '0;
      mod_o  <= '0;
    end else begin
      if (wr_i)   frac_o <= wdata_i;
      if (load_i) mod_o  <= frac_o;
    end
  end
endmodule

// File: rtl/pll_cfg_regs.sv
module pll_cfg_regs
  import pll_cfg_pkg::*;
#(
  parameter int unsigned NUM_PLL = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [1:0]         addr_i,
  input  logic               we_i,
  input  logic [15:0]        wdata_i,
  output logic [15:0]        rdata_o,
  input  logic [NUM_PLL-1:0] pll_on_i,
  input  logic [NUM_PLL-1:0] pll_rdy_i,
  output logic [1:0]         src_sel_o,
  output logic [5:0]         ref_div_o,
  output logic [1:0]         in_range_o,
  output logic               vco_med_o,
  output logic               p_en_o,
  output logic               q_en_o,
  output logic               r_en_o,
  output logic [12:0]        frac_o,
  output logic [12:0]        frac_mod_o,
  output logic               err_o
);
  localparam int unsigned CFG_W = $bits(cfg_t);

  cfg_t cfg_q, cfg_w;
  logic all_off, own_off;
  logic wr_cfg, wr_frac, wr_err;
  logic src_blk, div_blk, en_blk;
  logic [N_EN-1:0] en_d;
  logic latch_q;
  logic err_q;
  logic unused_w;

  assign wr_cfg  = we_i && (addr_i == A_CFG);
  assign wr_frac = we_i && (addr_i == A_FRAC);
  assign wr_err  = we_i && (addr_i == A_ERR);
  assign cfg_w   = cfg_t'(wdata_i[CFG_W-1:0]);
  assign unused_w = wdata_i[DATA_W-1];

  pll_cfg_lock #(.NUM_PLL(NUM_PLL)) u_lock (
    .pll_on_i  (pll_on_i),
    .pll_rdy_i (pll_rdy_i),
    .all_off_o (all_off),
    .own_off_o (own_off)
  );

  // blocked write counts as an error only when it would have changed the field
  assign src_blk = wr_cfg && !all_off && (cfg_w.src != cfg_q.src);
  assign div_blk = wr_cfg && !own_off && (cfg_w.div != cfg_q.div);
  assign en_blk  = wr_cfg && !own_off && (cfg_w.en  != cfg_q.en);

  for (genvar i = 0; i < N_EN; i++) begin : g_en
    always_comb en_d[i] = (wr_cfg && own_off) ? cfg_w.en[i] : cfg_q.en[i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
    end else if (wr_cfg) begin
      if (all_off) cfg_q.src <= cfg_w.src;
      if (own_off) cfg_q.div <= cfg_w.div;
      cfg_q.en      <= en_d;
      cfg_q.rng     <= cfg_w.rng;
      cfg_q.vco_med <= cfg_w.vco_med;
      cfg_q.latch   <= cfg_w.latch;
    end
  end

  assign latch_q = cfg_q.latch;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     err_q <= 1'b0;
    else if (wr_err && wdata_i[0])   err_q <= 1'b0;
    else if (src_blk || div_blk || en_blk) err_q <= 1'b1;
  end

  pll_cfg_frac #(.FRAC_W(FRAC_W)) u_frac (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr_frac),
    .wdata_i (wdata_i[FRAC_W-1:0]),
    .load_i  (wr_cfg && cfg_w.latch && !latch_q),
    .frac_o  (frac_o),
    .mod_o   (frac_mod_o)
  );

  always_comb begin
    case (addr_i)
      A_CFG:   rdata_o = DATA_W'(cfg_q);
      A_FRAC:  rdata_o = DATA_W'(frac_o);
      A_ERR:   rdata_o = DATA_W'(err_q);
      default: rdata_o = '0;
    endcase
  end

  assign src_sel_o  = cfg_q.src;
  assign ref_div_o  = cfg_q.div;
  assign in_range_o = cfg_q.rng;
  assign vco_med_o  = cfg_q.vco_med;
  assign p_en_o     = cfg_q.en[0];
  assign q_en_o     = cfg_q.en[1];
  assign r_en_o     = cfg_q.en[2];
  assign err_o      = err_q;
endmodule

// File: rtl/pll_cfg_regs_chk.sv
module pll_cfg_regs_chk #(
  parameter int unsigned NUM_PLL = 3
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [1:0]         addr_i,
  input logic               we_i,
  input logic [15:0]        wdata_i,
  input logic [NUM_PLL-1:0] pll_on_i,
  input logic [NUM_PLL-1:0] pll_rdy_i,
  input logic [1:0]         src_sel_o,
  input logic [5:0]         ref_div_o,
  input logic [1:0]         in_range_o,
  input logic               vco_med_o,
  input logic               p_en_o,
  input logic               q_en_o,
  input logic               r_en_o,
  input logic [12:0]        frac_mod_o,
  input logic               latch_i,
  input logic               err_o
);
  logic wr0;
  assign wr0 = we_i && (addr_i == 2'd0);

  a_r2_src_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr0 && (|(pll_on_i | pll_rdy_i))) |=> $stable(src_sel_o));

  a_r3_div_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr0 && (pll_on_i[0] || pll_rdy_i[0])) |=> $stable(ref_div_o));

  a_r4_en_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr0 && (pll_on_i[0] || pll_rdy_i[0])) |=> $stable({p_en_o, q_en_o, r_en_o}));

  a_r5_band_take: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr0 |=> ({vco_med_o, in_range_o} == $past(wdata_i[10:8])));

  a_r6_mod_no_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr0 && wdata_i[14] && !latch_i) |=> $stable(frac_mod_o));

  a_r7_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && !(we_i && addr_i == 2'd2 && wdata_i[0])) |=> err_o);
endmodule

bind pll_cfg_regs pll_cfg_regs_chk #(.NUM_PLL(NUM_PLL)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .addr_i     (addr_i),
  .we_i       (we_i),
  .wdata_i    (wdata_i),
  .pll_on_i   (pll_on_i),
  .pll_rdy_i  (pll_rdy_i),
  .src_sel_o  (src_sel_o),
  .ref_div_o  (ref_div_o),
  .in_range_o (in_range_o),
  .vco_med_o  (vco_med_o),
  .p_en_o     (p_en_o),
  .q_en_o     (q_en_o),
  .r_en_o     (r_en_o),
  .frac_mod_o (frac_mod_o),
  .latch_i    (latch_q),
  .err_o      (err_o)
);

// File: tb/pll_cfg_regs_bench.sv
`timescale 1ns/1ps
module pll_cfg_regs_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  addr_i = '0;
  logic        we_i = 1'b0;
  logic [15:0] wdata_i = '0;
  logic [15:0] rdata_o;
  logic [2:0]  pll_on_i = '0, pll_rdy_i = '0;
  logic [1:0]  src_sel_o, in_range_o;
  logic [5:0]  ref_div_o;
  logic        vco_med_o, p_en_o, q_en_o, r_en_o, err_o;
  logic [12:0] frac_o, frac_mod_o;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  // expected state
  logic [14:0] e_cfg = '0;
  logic [12:0] e_frac = '0, e_mod = '0;
  logic        e_err = 1'b0;

  always #10 clk_i = ~clk_i;

  pll_cfg_regs u_pll_cfg_regs (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; we_i = 1'b1;
    @(negedge clk_i);
    we_i = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [1:0] a, input logic [15:0] exp);
    addr_i = a; #1;
    chk(req, rdata_o, exp);
  endtask

  task automatic chk_outs();
    chk("R2 src", src_sel_o, e_cfg[1:0]);
    chk("R3 div", ref_div_o, e_cfg[7:2]);
    chk("R5 rng", in_range_o, e_cfg[9:8]);
    chk("R5 vco", vco_med_o, e_cfg[10]);
    chk("R4 en", {r_en_o, q_en_o, p_en_o}, e_cfg[13:11]);
    chk("R9 frac", frac_o, e_frac);
    chk("R6 mod", frac_mod_o, e_mod);
    chk("R7 err", err_o, e_err);
    rd_chk("R8 rd0", 2'd0, {1'b0, e_cfg});
    rd_chk("R8 rd1", 2'd1, {3'b0, e_frac});
    rd_chk("R8 rd2", 2'd2, {15'b0, e_err});
    rd_chk("R8 rd3", 2'd3, 16'h0);
  endtask

  // model of one word-0 write under current status
  task automatic cfg_write(input logic [15:0] d);
    logic all_off, own_off;
    all_off = ((pll_on_i | pll_rdy_i) == 3'b0);
    own_off = !(pll_on_i[0] || pll_rdy_i[0]);
    if (!all_off && d[1:0] != e_cfg[1:0]) e_err = 1'b1;
    if (!own_off && (d[7:2] != e_cfg[7:2] || d[13:11] != e_cfg[13:11])) e_err = 1'b1;
    if (d[14] && !e_cfg[14]) e_mod = e_frac;
    if (all_off) e_cfg[1:0] = d[1:0];
    if (own_off) begin e_cfg[7:2] = d[7:2]; e_cfg[13:11] = d[13:11]; end
    e_cfg[10:8] = d[10:8];
    e_cfg[14]   = d[14];
    wr(2'd0, d);
  endtask

  task automatic report();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      report();
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1: reset state
    chk("R1 src", src_sel_o, 0);
    chk("R1 div", ref_div_o, 0);
    chk("R1 en", {r_en_o, q_en_o, p_en_o}, 0);
    chk("R1 band", {vco_med_o, in_range_o}, 0);
    chk("R1 frac", {frac_o, frac_mod_o}, 0);
    chk("R1 err", err_o, 0);
    rst_ni = 1'b1;

    // sweep every status combination with varied data
    for (int s = 0; s < 64; s++) begin
      logic [15:0] d, f;
      pll_on_i  = s[2:0];
      pll_rdy_i = s[5:3];
      f = 16'((s * 997 + 123) ^ 16'hA5A5);
      e_frac = f[12:0];
      wr(2'd1, f);
      d = 16'((s * 16'h2C5B + 16'h1357) ^ (s << 9));
      cfg_write(d);
      chk_outs();
      // repeat latch=1 with new frac: no reload (R6)
      f = 16'(s * 31 + 7);
      e_frac = f[12:0];
      wr(2'd1, f);
      cfg_write(d | 16'h4000);
      cfg_write(d | 16'h4000);
      chk_outs();
      // clear latch and sticky error (R7)
      cfg_write(d & 16'h3FFF);
      if (e_err) begin
        chk("R7 still set", err_o, 1);
        wr(2'd2, 16'h0000);
        chk("R7 no clear on 0", err_o, 1);
        wr(2'd2, 16'h0001);
        e_err = 1'b0;
        chk("R7 cleared", err_o, 0);
      end
    end

    // explicit rising edge with all PLLs off
    pll_on_i = '0; pll_rdy_i = '0;
    cfg_write(16'h0000);
    wr(2'd1, 16'h1ABC); e_frac = 13'h1ABC;
    cfg_write(16'h7FFF);
    chk("R6 rise load", frac_mod_o, 13'h1ABC);
    chk_outs();

    // reset clears everything again
    @(negedge clk_i);
    rst_ni = 1'b0; #1;
    e_cfg = '0; e_frac = '0; e_mod = '0; e_err = 1'b0;
    chk_outs();

    done = 1;
    report();
  end
endmodule